// File: doc/BRIEF.md
# Event Dispatch Window Controller

This block sits in front of a set of functional units (several read units, several write units and one execute unit) and feeds them from one in-order stream of typed work events. Every event carries a kind, a unit identifier and an opaque tag. It is routed to exactly one unit port and handed over with a ready/valid handshake. The unit answers later with a one-cycle completion pulse.

The controller keeps a window of `WINDOW` slots. A slot is taken when an event is accepted from the stream. It is released only when the unit that received the event pulses its completion. Accepted events that are still waiting for their unit sit in an in-order queue inside the window. The window size therefore bounds how many events may be in flight at once across all units. Different units still work in parallel on events from the one stream. With `WINDOW = 1` the controller handles events strictly one at a time.

Top module: `evt_window_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready` is 1, `win_count` is 0 and no dispatch valid is raised.
- R2: `win_count` (events accepted but not yet completed) never exceeds `WINDOW`, and `in_ready` is 0 exactly when `win_count` equals `WINDOW`.
- R3: Kind 2'b00 goes to read port `in_id`, kind 2'b01 goes to write port `in_id`, and kinds 2'b10 and 2'b11 go to the execute port. An identifier at or above the unit count selects the highest-numbered unit of that kind. `disp_tag` carries the event's tag.
- R4: Events are dispatched in acceptance order. A head event whose unit is not ready blocks all later events, and at most one dispatch handshake completes per cycle.
- R5: A raised dispatch valid stays raised, with `disp_tag` unchanged, until the addressed unit is ready.
- R6: Each completion pulse frees one slot in the cycle after it, and pulses from several units in one cycle free one slot each. An acceptance and a completion in the same cycle leave `win_count` unchanged.
- R7: With `WINDOW = 1`, no further event is accepted or dispatched until the previous event's completion has been received.
- R8: Events bound for different units are dispatched one per cycle while earlier events are still outstanding, as long as window slots are free.
- R9: An event accepted while no earlier event is waiting raises its dispatch valid in the cycle right after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Event offered on the input stream |
| in_ready | output | 1 | Window has a free slot; event accepted when both are high |
| in_kind | input | 2 | Event kind: 00 read, 01 write, 1x execute |
| in_id | input | ID_W | Read or write unit index (ignored for execute) |
| in_tag | input | TAG_W | Opaque event tag passed to the unit |
| rd_valid | output | N_RD | Per read unit dispatch valid |
| rd_ready | input | N_RD | Per read unit ready |
| rd_done | input | N_RD | Per read unit completion pulse |
| wr_valid | output | N_WR | Per write unit dispatch valid |
| wr_ready | input | N_WR | Per write unit ready |
| wr_done | input | N_WR | Per write unit completion pulse |
| ex_valid | output | 1 | Execute unit dispatch valid |
| ex_ready | input | 1 | Execute unit ready |
| ex_done | input | 1 | Execute unit completion pulse |
| disp_tag | output | TAG_W | Tag of the event currently offered to a unit |
| win_count | output | $clog2(WINDOW)+1 | Number of occupied window slots |

## Verification
The checks assume that the units behave well. A unit pulses completion only for an event it has already taken, at most once per event, and its pulse is one cycle long. Under that assumption the count of dispatched but unfinished events, which is rebuilt from the port handshakes, can never go negative. The stimulus follows this rule: every completion pulse in the bench is issued only after the matching dispatch handshake has been seen, and total pulses never outnumber dispatched events. Input kind, identifier and tag are held steady while `in_valid` waits for `in_ready`, as a well-formed ready/valid source would do.

// File: rtl/evt_window_pkg.sv
package evt_window_pkg;

   typedef enum logic [1:0] {
      EV_READ     = 2'b00,
      EV_WRITE    = 2'b01,
      EV_EXEC     = 2'b10,
      EV_EXEC_ALT = 2'b11
   } ev_kind_e;

   // An identifier clamped to the highest unit of its class.
   function automatic int unsigned clamp_sel(input int unsigned id_val,
                                             input int unsigned n_units);
      return (id_val >= n_units) ? (n_units - 1) : id_val;
   endfunction

endpackage

// File: rtl/evt_queue.sv
module evt_queue #(
   parameter int DEPTH   = 4,
   parameter int ENTRY_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               push,
   input  logic [ENTRY_W-1:0] push_data,
   input  logic               pop,
   output logic               head_valid,
   output logic [ENTRY_W-1:0] head_data
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("evt_queue: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_single
      // One holding register; the window bound keeps push away while full.
      logic               full_q;
      logic [ENTRY_W-1:0] data_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
         end else begin
            full_q <= push | (full_q & ~pop);
            if (push) begin
               data_q <= push_data;
            end
         end
      end

      assign head_valid = full_q;
      assign head_data  = data_q;
   end else begin : g_ring
      localparam int PTR_W = $clog2(DEPTH);
      localparam int CNT_W = $clog2(DEPTH + 1);
      localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

      logic [ENTRY_W-1:0] mem_q [DEPTH];
      logic [PTR_W-1:0]   wr_ptr_q;
      logic [PTR_W-1:0]   rd_ptr_q;
      logic [CNT_W-1:0]   fill_q;
      logic               do_pop;

      assign do_pop     = pop & (fill_q != '0);
      assign head_valid = (fill_q != '0);
      assign head_data  = mem_q[rd_ptr_q];

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
         end else begin
            if (push) begin
               wr_ptr_q <= (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + 1'b1;
            end
            if (do_pop) begin
               rd_ptr_q <= (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + 1'b1;
            end
            case ({push, do_pop})
               2'b10:   fill_q <= fill_q + 1'b1;
               2'b01:   fill_q <= fill_q - 1'b1;
               default: fill_q <= fill_q;
            endcase
         end
      end

      for (genvar e = 0; e < DEPTH; e++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               mem_q[e] <= '0;
            end else if (push && (wr_ptr_q == PTR_W'(e))) begin
               mem_q[e] <= push_data;
            end
         end
      end
   end

endmodule

// File: rtl/evt_router.sv
module evt_router
   import evt_window_pkg::*;
#(
   parameter int N_RD = 2,
   parameter int N_WR = 2,
   parameter int ID_W = 2
) (
   input  logic            head_valid,
   input  logic [1:0]      head_kind,
   input  logic [ID_W-1:0] head_id,
   input  logic [N_RD-1:0] rd_ready,
   input  logic [N_WR-1:0] wr_ready,
   input  logic            ex_ready,
   output logic [N_RD-1:0] rd_valid,
   output logic [N_WR-1:0] wr_valid,
   output logic            ex_valid,
   output logic            fire
);

   logic is_rd;
   logic is_wr;
   logic is_ex;
   int unsigned rd_sel;
   int unsigned wr_sel;

   assign is_rd = head_valid & (head_kind == EV_READ);
   assign is_wr = head_valid & (head_kind == EV_WRITE);
   assign is_ex = head_valid & head_kind[1];

   always_comb begin
      rd_sel = clamp_sel(int'(head_id), N_RD);
      wr_sel = clamp_sel(int'(head_id), N_WR);
   end

   for (genvar r = 0; r < N_RD; r++) begin : g_rd
      assign rd_valid[r] = is_rd & (rd_sel == r);
   end

   for (genvar w = 0; w < N_WR; w++) begin : g_wr
      assign wr_valid[w] = is_wr & (wr_sel == w);
   end

   assign ex_valid = is_ex;
   assign fire     = (|(rd_valid & rd_ready)) | (|(wr_valid & wr_ready))
                   | (ex_valid & ex_ready);

endmodule

// File: rtl/evt_occ_counter.sv
module evt_occ_counter #(
   parameter int WINDOW = 4,
   parameter int N_DONE = 5,
   parameter int CNT_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [N_DONE-1:0] done,
   output logic [CNT_W-1:0]  count,
   output logic              full
);

   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(WINDOW);

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] n_done;

   always_comb begin
      n_done = '0;
      for (int i = 0; i < N_DONE; i++) begin
         n_done = n_done + CNT_W'(done[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
      end else begin
         count_q <= count_q + CNT_W'(accept) - n_done;
      end
   end

   assign count = count_q;
   assign full  = (count_q == LIMIT);

endmodule

// File: rtl/evt_window_ctrl.sv
module evt_window_ctrl
   import evt_window_pkg::*;
#(
   parameter int WINDOW = 4,
   parameter int N_RD   = 2,
   parameter int N_WR   = 2,
   parameter int ID_W   = 2,
   parameter int TAG_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [1:0]                in_kind,
   input  logic [ID_W-1:0]           in_id,
   input  logic [TAG_W-1:0]          in_tag,
   output logic [N_RD-1:0]           rd_valid,
   input  logic [N_RD-1:0]           rd_ready,
   input  logic [N_RD-1:0]           rd_done,
   output logic [N_WR-1:0]           wr_valid,
   input  logic [N_WR-1:0]           wr_ready,
   input  logic [N_WR-1:0]           wr_done,
   output logic                      ex_valid,
   input  logic                      ex_ready,
   input  logic                      ex_done,
   output logic [TAG_W-1:0]          disp_tag,
   output logic [$clog2(WINDOW):0]   win_count
);

   localparam int CNT_W   = $clog2(WINDOW) + 1;
   localparam int ENTRY_W = 2 + ID_W + TAG_W;
   localparam int N_DONE  = N_RD + N_WR + 1;
   localparam int N_MAX   = (N_RD > N_WR) ? N_RD : N_WR;

   if (WINDOW < 1) begin : g_chk_window
      $error("evt_window_ctrl: WINDOW must be at least 1");
   end
   if (N_RD < 1 || N_WR < 1) begin : g_chk_units
      $error("evt_window_ctrl: need at least one read and one write unit");
   end
   if ((1 << ID_W) < N_MAX) begin : g_chk_id
      $error("evt_window_ctrl: ID_W too narrow for the unit count");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("evt_window_ctrl: TAG_W must be at least 1");
   end

   logic               accept;
   logic               full;
   logic               head_valid;
   logic [ENTRY_W-1:0] head_data;
   logic [1:0]         head_kind;
   logic [ID_W-1:0]    head_id;
   logic               fire;
   logic [CNT_W-1:0]   count;

   assign in_ready = ~full;
   assign accept   = in_valid & ~full;

   evt_occ_counter #(
      .WINDOW (WINDOW),
      .N_DONE (N_DONE),
      .CNT_W  (CNT_W)
   ) occ_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .done   ({ex_done, wr_done, rd_done}),
      .count  (count),
      .full   (full)
   );

   evt_queue #(
      .DEPTH   (WINDOW),
      .ENTRY_W (ENTRY_W)
   ) queue_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (accept),
      .push_data  ({in_kind, in_id, in_tag}),
      .pop        (fire),
      .head_valid (head_valid),
      .head_data  (head_data)
   );

   assign head_kind = head_data[ENTRY_W-1 -: 2];
   assign head_id   = head_data[TAG_W +: ID_W];
   assign disp_tag  = head_data[TAG_W-1:0];

   evt_router #(
      .N_RD (N_RD),
      .N_WR (N_WR),
      .ID_W (ID_W)
   ) router_i (
      .head_valid (head_valid),
      .head_kind  (head_kind),
      .head_id    (head_id),
      .rd_ready   (rd_ready),
      .wr_ready   (wr_ready),
      .ex_ready   (ex_ready),
      .rd_valid   (rd_valid),
      .wr_valid   (wr_valid),
      .ex_valid   (ex_valid),
      .fire       (fire)
   );

   assign win_count = count;

endmodule

// File: rtl/evt_window_chk.sv
module evt_window_chk #(
   parameter int WINDOW = 4,
   parameter int N_RD   = 2,
   parameter int N_WR   = 2,
   parameter int ID_W   = 2,
   parameter int TAG_W  = 8
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    in_ready,
   input logic [N_RD-1:0]         rd_valid,
   input logic [N_RD-1:0]         rd_ready,
   input logic [N_RD-1:0]         rd_done,
   input logic [N_WR-1:0]         wr_valid,
   input logic [N_WR-1:0]         wr_ready,
   input logic [N_WR-1:0]         wr_done,
   input logic                    ex_valid,
   input logic                    ex_ready,
   input logic                    ex_done,
   input logic [TAG_W-1:0]        disp_tag,
   input logic [$clog2(WINDOW):0] win_count
);

   localparam int NU  = N_RD + N_WR + 1;
   localparam int SW  = $clog2(WINDOW) + 3;

   logic [NU-1:0] vld;
   logic [NU-1:0] rdy;
   logic [NU-1:0] dn;
   logic [SW-1:0] shadow_occ;
   logic [SW-1:0] shadow_out;
   logic [SW-1:0] n_dn;
   logic          acc;
   logic          hs;

   assign vld = {ex_valid, wr_valid, rd_valid};
   assign rdy = {ex_ready, wr_ready, rd_ready};
   assign dn  = {ex_done, wr_done, rd_done};
   assign acc = in_valid & in_ready;
   assign hs  = |(vld & rdy);

   always_comb begin
      n_dn = '0;
      for (int i = 0; i < NU; i++) begin
         n_dn = n_dn + SW'(dn[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_occ <= '0;
         shadow_out <= '0;
      end else begin
         shadow_occ <= shadow_occ + SW'(acc) - n_dn;
         shadow_out <= shadow_out + SW'(hs) - n_dn;
      end
   end

   // R2
   win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      SW'(win_count) <= SW'(WINDOW));

   // R2
   full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (SW'(win_count) == SW'(WINDOW)) |-> !in_ready);

   // R4
   one_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld & rdy) <= 1);

   // R5
   hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|vld) && !hs) |=> ((vld == $past(vld)) && $stable(disp_tag)));

   // R6
   occ_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      SW'(win_count) == shadow_occ);

   // R7
   inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shadow_out <= SW'(WINDOW));

endmodule

bind evt_window_ctrl evt_window_chk #(
   .WINDOW (WINDOW),
   .N_RD   (N_RD),
   .N_WR   (N_WR),
   .ID_W   (ID_W),
   .TAG_W  (TAG_W)
) chk_i (.*);

// File: tb/evt_window_ctrl_tb_top.sv
module evt_window_ctrl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int W    = 4;
   localparam int TAGW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_checks = 0;
   int n_fails  = 0;
   bit finished = 1'b0;

   // main instance, WINDOW = 4
   logic            in_valid = 1'b0;
   logic            in_ready;
   logic [1:0]      in_kind = 2'b00;
   logic [1:0]      in_id = 2'b00;
   logic [TAGW-1:0] in_tag = '0;
   logic [4:0]      ready_v = 5'b11111;
   logic [4:0]      done_v = 5'b00000;
   logic [1:0]      rd_valid;
   logic [1:0]      wr_valid;
   logic            ex_valid;
   logic [TAGW-1:0] disp_tag;
   logic [2:0]      win_count;
   logic [4:0]      vld;
   int              exp_cnt = 0;

   assign vld = {ex_valid, wr_valid, rd_valid};

   evt_window_ctrl #(.WINDOW(W), .N_RD(2), .N_WR(2), .ID_W(2), .TAG_W(TAGW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .in_id(in_id), .in_tag(in_tag),
      .rd_valid(rd_valid), .rd_ready(ready_v[1:0]), .rd_done(done_v[1:0]),
      .wr_valid(wr_valid), .wr_ready(ready_v[3:2]), .wr_done(done_v[3:2]),
      .ex_valid(ex_valid), .ex_ready(ready_v[4]), .ex_done(done_v[4]),
      .disp_tag(disp_tag), .win_count(win_count)
   );

   // sequential instance, WINDOW = 1
   logic            s_in_valid = 1'b0;
   logic            s_in_ready;
   logic [1:0]      s_in_kind = 2'b00;
   logic [1:0]      s_in_id = 2'b00;
   logic [TAGW-1:0] s_in_tag = '0;
   logic [4:0]      s_done_v = 5'b00000;
   logic [1:0]      s_rd_valid;
   logic [1:0]      s_wr_valid;
   logic            s_ex_valid;
   logic [TAGW-1:0] s_disp_tag;
   logic [0:0]      s_win_count;
   logic [4:0]      s_vld;

   assign s_vld = {s_ex_valid, s_wr_valid, s_rd_valid};

   evt_window_ctrl #(.WINDOW(1), .N_RD(2), .N_WR(2), .ID_W(2), .TAG_W(TAGW)) seq_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(s_in_valid), .in_ready(s_in_ready),
      .in_kind(s_in_kind), .in_id(s_in_id), .in_tag(s_in_tag),
      .rd_valid(s_rd_valid), .rd_ready(2'b11), .rd_done(s_done_v[1:0]),
      .wr_valid(s_wr_valid), .wr_ready(2'b11), .wr_done(s_done_v[3:2]),
      .ex_valid(s_ex_valid), .ex_ready(1'b1), .ex_done(s_done_v[4]),
      .disp_tag(s_disp_tag), .win_count(s_win_count)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Expected port vector {ex, wr1, wr0, rd1, rd0} from the R3 routing rule.
   function automatic logic [4:0] route_vec(input logic [1:0] kind, input logic [1:0] id);
      int sel;
      sel = (id > 1) ? 1 : int'(id);
      if (kind[1])          return 5'b10000;
      else if (kind == 2'b00) return 5'(1 << sel);
      else                  return 5'(1 << (2 + sel));
   endfunction

   // One clock of the main instance with its occupancy model (R2, R6).
   task automatic step();
      bit acc;
      #2;
      acc = in_valid && (exp_cnt != W);
      check(in_ready == (exp_cnt != W), "R2 in_ready", int'(in_ready), int'(exp_cnt != W));
      @(posedge clk);
      #1;
      exp_cnt = exp_cnt + int'(acc) - $countones(done_v);
      check(int'(win_count) == exp_cnt, "R6 win_count", int'(win_count), exp_cnt);
   endtask

   task automatic check_disp(input logic [4:0] exp_v, input logic [TAGW-1:0] exp_tag,
                             input string req);
      check(vld == exp_v, req, int'(vld), int'(exp_v));
      if (exp_v != 5'b0) begin
         check(disp_tag == exp_tag, {req, " tag"}, int'(disp_tag), int'(exp_tag));
      end
   endtask

   task automatic offer(input logic [1:0] k, input logic [1:0] id, input logic [TAGW-1:0] t);
      in_valid = 1'b1;
      in_kind  = k;
      in_id    = id;
      in_tag   = t;
   endtask

   task automatic t_reset();
      #1;
      check(in_ready == 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
      check(win_count == 3'd0, "R1 count in reset", int'(win_count), 0);
      check(vld == 5'b0, "R1 no dispatch in reset", int'(vld), 0);
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(in_ready == 1'b1 && s_in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
      check(win_count == 3'd0, "R1 count after reset", int'(win_count), 0);
      check(vld == 5'b0 && s_vld == 5'b0, "R1 no dispatch after reset", int'(vld), 0);
   endtask

   // R3, R9: each event kind and identifier reaches its own port.
   task automatic t_route(input logic [1:0] k, input logic [1:0] id, input logic [TAGW-1:0] t);
      logic [4:0] ev;
      ev = route_vec(k, id);
      ready_v = 5'b11111;
      offer(k, id, t);
      step();
      in_valid = 1'b0;
      check_disp(ev, t, "R3 R9 routing");
      step();
      check_disp(5'b0, t, "R3 taken after handshake");
      done_v = ev;
      step();
      done_v = 5'b0;
      check(win_count == 3'd0, "R6 slot freed", int'(win_count), 0);
   endtask

   // R2, R6: fill the window, stall intake, overlapping accept and completion.
   task automatic t_full();
      ready_v = 5'b00000;
      for (int i = 0; i < W; i++) begin
         offer(2'b00, 2'b00, TAGW'(8'h40 + i));
         step();
      end
      check(in_ready == 1'b0, "R2 full stalls intake", int'(in_ready), 0);
      check(win_count == 3'd4, "R2 count at window", int'(win_count), 4);
      offer(2'b00, 2'b00, 8'h4F);
      step();
      step();
      check(win_count == 3'd4, "R2 no accept while full", int'(win_count), 4);
      in_valid = 1'b0;
      ready_v = 5'b00001;
      for (int i = 0; i < W; i++) begin
         check_disp(5'b00001, TAGW'(8'h40 + i), "R4 in-order from full window");
         step();
      end
      check_disp(5'b0, 8'h0, "R4 queue drained");
      done_v = 5'b00001;
      step();
      check(win_count == 3'd3, "R6 single completion", int'(win_count), 3);
      offer(2'b00, 2'b00, 8'h4F);
      step();
      check(win_count == 3'd3, "R6 accept with completion", int'(win_count), 3);
      in_valid = 1'b0;
      check_disp(5'b00001, 8'h4F, "R9 dispatch after refill");
      for (int i = 0; i < 3; i++) begin
         step();
      end
      done_v = 5'b0;
      check(win_count == 3'd0, "R6 drained", int'(win_count), 0);
   endtask

   // R4, R5: a blocked head holds back a later event for a ready unit.
   task automatic t_order();
      ready_v = 5'b11011;
      offer(2'b01, 2'b00, 8'hA1);
      step();
      offer(2'b00, 2'b00, 8'hB2);
      step();
      in_valid = 1'b0;
      for (int i = 0; i < 3; i++) begin
         check_disp(5'b00100, 8'hA1, "R4 R5 head held, later event blocked");
         step();
      end
      ready_v = 5'b11111;
      step();
      check_disp(5'b00001, 8'hB2, "R4 next event after head leaves");
      step();
      check_disp(5'b0, 8'h0, "R4 both taken");
      done_v = 5'b00101;
      step();
      done_v = 5'b0;
      check(win_count == 3'd0, "R6 two completions in one cycle", int'(win_count), 0);
   endtask

   // R8: events to different units go out back to back with none completed.
   task automatic t_concurrent();
      ready_v = 5'b11111;
      offer(2'b00, 2'b01, 8'hC1);
      step();
      check_disp(5'b00010, 8'hC1, "R8 read dispatched");
      offer(2'b01, 2'b01, 8'hC2);
      step();
      check_disp(5'b01000, 8'hC2, "R8 write dispatched while read busy");
      offer(2'b10, 2'b00, 8'hC3);
      step();
      in_valid = 1'b0;
      check_disp(5'b10000, 8'hC3, "R8 execute dispatched while others busy");
      step();
      check(win_count == 3'd3, "R8 three in flight", int'(win_count), 3);
      done_v = 5'b11010;
      step();
      done_v = 5'b0;
      check(win_count == 3'd0, "R6 three completions", int'(win_count), 0);
   endtask

   // R7: window of one handles events strictly one after another.
   task automatic t_seq();
      s_in_valid = 1'b1;
      s_in_kind  = 2'b00;
      s_in_id    = 2'b00;
      s_in_tag   = 8'h11;
      #2;
      check(s_in_ready == 1'b1, "R7 first accepted", int'(s_in_ready), 1);
      @(posedge clk);
      #1;
      s_in_id  = 2'b01;
      s_in_tag = 8'h22;
      #1;
      check(s_in_ready == 1'b0, "R7 intake closed", int'(s_in_ready), 0);
      check(s_vld == 5'b00001 && s_disp_tag == 8'h11, "R7 first dispatched",
            int'(s_vld), 1);
      @(posedge clk);
      for (int i = 0; i < 3; i++) begin
         #2;
         check(s_vld == 5'b0 && s_in_ready == 1'b0, "R7 waits for completion",
               int'({s_vld, s_in_ready}), 0);
         @(posedge clk);
      end
      #1;
      s_done_v = 5'b00001;
      @(posedge clk);
      #1;
      s_done_v = 5'b0;
      check(s_in_ready == 1'b1 && s_win_count == 1'b0, "R7 reopened after completion",
            int'(s_in_ready), 1);
      @(posedge clk);
      #1;
      s_in_valid = 1'b0;
      #1;
      check(s_vld == 5'b00010 && s_disp_tag == 8'h22, "R7 second dispatched",
            int'(s_vld), 2);
      @(posedge clk);
      #1;
      s_done_v = 5'b00010;
      @(posedge clk);
      #1;
      s_done_v = 5'b0;
   endtask

   initial begin
      t_reset();
      t_route(2'b00, 2'b00, 8'h10);
      t_route(2'b00, 2'b01, 8'h11);
      t_route(2'b01, 2'b00, 8'h12);
      t_route(2'b01, 2'b01, 8'h13);
      t_route(2'b10, 2'b00, 8'h14);
      t_route(2'b11, 2'b01, 8'h15);
      t_route(2'b00, 2'b11, 8'h16);
      t_route(2'b01, 2'b10, 8'h17);
      t_full();
      t_order();
      t_concurrent();
      t_seq();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!finished) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   end

endmodule